// File: doc/BRIEF.md
# Bus Access Repeat-Suppression Monitor

The monitor samples a register bus, one access per cycle when its valid strobe is high. Each access has a direction (read or write), an address and a data value. The monitor keeps a copy of the last access it recorded. An access that equals that copy in all three fields is a repeat. A repeat produces no trace record and only advances a saturating repeat counter. Any other access produces a trace record.

Trace records leave the block two cycles after their access is sampled. If repeats were folded away since the last record, a repeat-summary strobe carrying the count appears one cycle before the next record. A debug log built from the two output streams therefore reads in bus order: a record, then how often it recurred, then the next record.

A flush input empties a pending non-zero count at any time. Software uses it to close a log without waiting for a new access.

Top module: `bus_repeat_filter`

## Requirements
- R1: While reset is active, and in the first cycle after it, `rec_valid` and `sum_valid` are 0. Reset discards the stored reference, so the first access after reset always yields a record.
- R2: An access is a repeat when its direction, address and data all equal those of the stored reference. A repeat yields no trace record. Idle cycles between accesses do not break a run.
- R3: An access that differs from the reference in direction alone, in address alone or in data alone yields a trace record.
- R4: A new access sampled at clock edge k drives `rec_valid` high after edge k+2. `rec_write`, `rec_addr` and `rec_data` then carry that access. A new access becomes the reference.
- R5: Each repeat raises the internal count by one. When a new access is sampled at edge k and the count is non-zero, `sum_valid` is high after edge k+1 and `sum_count` holds the count. `sum_count` is never zero while `sum_valid` is high.
- R6: A summary caused by a new access comes exactly one cycle before that access's trace record.
- R7: A new access clears the count, so the next run is counted from zero.
- R8: The count saturates at 2^CNT_W-1 and does not wrap.
- R9: A flush sampled with a non-zero count and no new access raises `sum_valid` one cycle later with that count, and clears it. A flush with a zero count has no effect on the outputs.
- R10: A flush sampled together with a repeat reports the count including that repeat. The reference stays as it was, so a further identical access is still a repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access address |
| acc_data | input | DATA_W | Access data value |
| flush | input | 1 | Emit any pending non-zero repeat count |
| rec_valid | output | 1 | Trace record strobe |
| rec_write | output | 1 | Recorded direction |
| rec_addr | output | ADDR_W | Recorded address |
| rec_data | output | DATA_W | Recorded data |
| sum_valid | output | 1 | Repeat-summary strobe |
| sum_count | output | CNT_W | Number of folded repeats |

## Verification
The bench builds the monitor with 32-bit address and data and with CNT_W = 3. A count limit of 7 lets runs of one to ten identical accesses be swept and reach saturation within a few cycles. Every cycle is compared against an arithmetic model of the expected summary and record streams. The bench covers single-field differences, idle gaps inside runs, flushes with and without a pending count, a flush that coincides with a repeat, and a reset in the middle of a run.

// File: rtl/bus_repeat_filter.sv
module bus_repeat_filter #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              flush,
  output logic              rec_valid,
  output logic              rec_write,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [DATA_W-1:0] rec_data,
  output logic              sum_valid,
  output logic [CNT_W-1:0]  sum_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              ref_ok, ref_write;
  logic [ADDR_W-1:0] ref_addr;
  logic [DATA_W-1:0] ref_data;
  logic [CNT_W-1:0]  cnt;
  logic              stg_valid, stg_write;
  logic [ADDR_W-1:0] stg_addr;
  logic [DATA_W-1:0] stg_data;

  wire same  = ref_ok && acc_write == ref_write && acc_addr == ref_addr && acc_data == ref_data;
  wire dup   = acc_valid && same;
  wire fresh = acc_valid && !same;

  wire [CNT_W-1:0] cnt_bump = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  wire [CNT_W-1:0] cnt_held = dup ? cnt_bump : cnt;
  wire             emit     = fresh ? (cnt != '0) : (flush && cnt_held != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_ok    <= 1'b0;
      ref_write <= 1'b0;
      ref_addr  <= '0;
      ref_data  <= '0;
      cnt       <= '0;
      stg_valid <= 1'b0;
      stg_write <= 1'b0;
      stg_addr  <= '0;
      stg_data  <= '0;
      rec_valid <= 1'b0;
      rec_write <= 1'b0;
      rec_addr  <= '0;
      rec_data  <= '0;
      sum_valid <= 1'b0;
      sum_count <= '0;
    end else begin
      sum_valid <= emit;
      sum_count <= emit ? (fresh ? cnt : cnt_held) : '0;
      cnt       <= (fresh || flush) ? '0 : cnt_held;
      stg_valid <= fresh;
      if (fresh) begin
        ref_ok    <= 1'b1;
        ref_write <= acc_write;
        ref_addr  <= acc_addr;
        ref_data  <= acc_data;
        stg_write <= acc_write;
        stg_addr  <= acc_addr;
        stg_data  <= acc_data;
      end
      rec_valid <= stg_valid;
      rec_write <= stg_write;
      rec_addr  <= stg_addr;
      rec_data  <= stg_data;
    end
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> !rec_valid && !sum_valid);
  p_dup_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dup |=> ##1 !rec_valid);
  p_rec_from_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |=> ##1 rec_valid && rec_addr == $past(acc_addr, 2) && rec_data == $past(acc_data, 2));
  p_sum_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> sum_count != '0);
  p_sum_before_rec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid && $past(acc_valid) && !$past(flush) |=> rec_valid);
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dup && cnt == CNT_MAX && !flush |=> cnt == CNT_MAX);
  p_flush_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !acc_valid && cnt != '0 |=> sum_valid && sum_count == $past(cnt) && cnt == '0);
endmodule

// File: tb/test_bus_repeat_filter.sv
module test_bus_repeat_filter;
  localparam int CW = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, flush = 1'b0;
  logic [31:0] acc_addr = '0, acc_data = '0;
  logic        rec_valid, rec_write, sum_valid;
  logic [31:0] rec_addr, rec_data;
  logic [CW-1:0] sum_count;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  bit m_ok, m_w; logic [31:0] m_a, m_d; int m_cnt;
  bit s_v, s_w; logic [31:0] s_a, s_d;

  always #10 clk = ~clk;

  bus_repeat_filter #(.ADDR_W(32), .DATA_W(32), .CNT_W(CW)) i_bus_repeat_filter (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_data(acc_data), .flush(flush),
    .rec_valid(rec_valid), .rec_write(rec_write), .rec_addr(rec_addr), .rec_data(rec_data),
    .sum_valid(sum_valid), .sum_count(sum_count));

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0; acc_valid = 1'b0; flush = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(tag, !rec_valid && !sum_valid, $sformatf("rec=%0b sum=%0b", rec_valid, sum_valid), "rec=0 sum=0");
    rst_n = 1'b1;
    m_ok = 0; m_cnt = 0; s_v = 0;
    @(posedge clk); @(negedge clk);
    check(tag, !rec_valid && !sum_valid, $sformatf("rec=%0b sum=%0b", rec_valid, sum_valid), "rec=0 sum=0");
  endtask

  task automatic step(input string tag, input bit v, input bit w, input logic [31:0] a,
                      input logic [31:0] d, input bit f);
    bit dup, fresh, es_v, er_v, er_w;
    int held, es_c;
    logic [31:0] er_a, er_d;
    dup   = v && m_ok && w == m_w && a == m_a && d == m_d;
    fresh = v && !dup;
    held  = dup ? ((m_cnt + 1 > MAXC) ? MAXC : m_cnt + 1) : m_cnt;
    if (fresh) begin es_v = (m_cnt != 0); es_c = m_cnt; end
    else begin es_v = f && held != 0; es_c = held; end
    er_v = s_v; er_w = s_w; er_a = s_a; er_d = s_d;
    s_v = fresh; s_w = w; s_a = a; s_d = d;
    if (fresh) begin m_ok = 1; m_w = w; m_a = a; m_d = d; end
    m_cnt = (fresh || f) ? 0 : held;
    acc_valid = v; acc_write = w; acc_addr = a; acc_data = d; flush = f;
    @(posedge clk); @(negedge clk);
    check(tag,
      sum_valid == es_v && (!es_v || sum_count == CW'(es_c)) && rec_valid == er_v &&
      (!er_v || (rec_write == er_w && rec_addr == er_a && rec_data == er_d)),
      $sformatf("sum=%0b/%0d rec=%0b/%0b/%h/%h", sum_valid, sum_count, rec_valid, rec_write, rec_addr, rec_data),
      $sformatf("sum=%0b/%0d rec=%0b/%0b/%h/%h", es_v, es_c, er_v, er_w, er_a, er_d));
  endtask

  task automatic idle(input string tag, input int k);
    for (int i = 0; i < k; i++) step(tag, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset("R1");
    step("R1 first access is new", 1, 1, 32'h40, 32'hA5, 0);
    idle("R4", 3);

    for (int n = 1; n <= 10; n++) begin
      for (int k = 0; k < n; k++)
        step("R2 R5 R8 run", 1, n[0], 32'h1000 + n, n * 3, 0);
    end
    step("R6 R7 run closed", 1, 0, 32'h2000, 32'h1, 0);
    idle("R6", 3);

    step("R3 base", 1, 0, 32'h50, 32'h77, 0);
    step("R3 dir only", 1, 1, 32'h50, 32'h77, 0);
    step("R3 addr only", 1, 1, 32'h54, 32'h77, 0);
    step("R3 data only", 1, 1, 32'h54, 32'h78, 0);
    step("R2 repeat", 1, 1, 32'h54, 32'h78, 0);
    idle("R2 gap", 2);
    step("R2 repeat after gap", 1, 1, 32'h54, 32'h78, 0);
    idle("R5", 1);

    for (int c = 0; c <= MAXC + 2; c++) begin
      step("R9 base", 1, 0, 32'h3000 + c, 32'h0, 0);
      for (int k = 0; k < c; k++) step("R9 repeat", 1, 0, 32'h3000 + c, 32'h0, 0);
      step("R9 flush", 0, 0, 0, 0, 1);
      step("R9 flush again empty", 0, 0, 0, 0, 1);
    end

    step("R10 base", 1, 1, 32'h60, 32'h9, 0);
    step("R10 repeat", 1, 1, 32'h60, 32'h9, 0);
    step("R10 repeat with flush", 1, 1, 32'h60, 32'h9, 1);
    step("R10 still repeat", 1, 1, 32'h60, 32'h9, 0);
    step("R10 new", 1, 0, 32'h64, 32'h9, 0);
    step("R10 new with flush", 1, 0, 32'h68, 32'h9, 1);
    idle("R10", 3);

    step("R1 run before reset", 1, 0, 32'h70, 32'h1, 0);
    step("R1 run before reset", 1, 0, 32'h70, 32'h1, 0);
    do_reset("R1 mid-run reset");
    step("R1 same access is new after reset", 1, 0, 32'h70, 32'h1, 0);
    step("R1 no stale summary", 1, 0, 32'h74, 32'h1, 0);
    idle("R1 R4", 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule